// File: doc/BRIEF.md
# Buffered-Reload Up-Counting Timer Base

This block is the counting core of a general-purpose timer. A 16-bit counter climbs from zero to an active period value, returns to zero and, when overflow events are allowed, raises a sticky interrupt flag. Count steps come from a 16-bit prescaler. The prescaler is fed either by every cycle of the timer clock or by rising edges of one of four internal trigger lines, so one timer can be clocked by another timer's trigger output.

The divisor and the period are written through simple write-enable/data ports into preload registers. Separate shadow copies hold the values in use. A new divisor always waits for an overflow event before it takes effect. A new period takes effect at once or at the next overflow event, depending on a buffering bit. Turning off overflow events also stops both reloads. The enable bit reaches the counting logic one cycle after it is written.

Top module: `tmrb_top`

## Requirements
- R1: While running, the count advances by one per count step from 0 up to the active period. The step taken at the active period returns the count to 0 and is an overflow. When overflow events are enabled, that overflow sets the flag.
- R2: With an active divisor of N, the counter takes one step per N+1 source ticks. The source tick is every clock in internal mode.
- R3: A divisor write only updates the preload. The active divisor takes the preload value at the next overflow event and at no other time.
- R4: With the period-buffer bit at 0, a period write sets the active period in the same edge. With the bit at 1, the write reaches the active period only at the next overflow event.
- R5: With overflow events disabled, the counter still wraps at the active period. The flag is not set, and neither the active divisor nor the active period reloads.
- R6: An enable write takes effect on counting one clock later. After enable is written at edge k, the first count step happens at edge k+2 with divisor 0. After disable is written at edge k, a step can still occur at edge k+1.
- R7: In external mode, a source tick is a rising edge of the trigger line picked by the 3-bit selector, codes 0 to 3. It is sampled in the timer clock, and a change counts at the first edge that sees it high. Unselected lines are ignored. Codes 4 to 7 select no line.
- R8: The overflow flag stays set until the clear input is pulsed. If a clear and an overflow event fall in the same cycle, the flag stays set.
- R9: While disabled, the count holds and the prescaler phase returns to 0. Writes to the divisor, period and mode bits are still accepted.
- R10: After reset, the count is 0, the flag is 0, the timer is disabled, the active divisor is 0, the active period is all ones, period buffering is off and overflow events are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enWrEn | input | 1 | Write strobe for the enable bit |
| enWrData | input | 1 | Enable value |
| divWrEn | input | 1 | Write strobe for the divisor preload |
| divWrData | input | 16 | Divisor value |
| perWrEn | input | 1 | Write strobe for the period |
| perWrData | input | 16 | Period value |
| perBufWrEn | input | 1 | Write strobe for the period-buffer bit |
| perBufWrData | input | 1 | 1 = buffered period, 0 = immediate period |
| ovfEvtWrEn | input | 1 | Write strobe for the overflow-event enable |
| ovfEvtWrData | input | 1 | 1 = overflow events allowed |
| extMode | input | 1 | 1 = count from the selected trigger, 0 = from the clock |
| trigSel | input | 3 | Trigger line select |
| trigIn | input | 4 | Internal trigger lines |
| flagClr | input | 1 | Clears the overflow flag |
| count | output | 16 | Counter value |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The counter is run with divisor 0 and with divisors 1 and 2. Holding the count over the expected number of clocks separates a divisor applied at the wrong time from one applied at the right time. Period writes are made in immediate and in buffered mode while the count is below the old period, so an early reload shows up as an early wrap. An early, late or missing enable shows up in the edge of the first step, and in the extra step after a disable. Trigger patterns pulse an unselected line, hold the selected line high, and toggle all lines under an out-of-range code. Together they separate edge counting from level counting and wrong selection.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;
  typedef struct packed {
    logic enActive;
    logic cntTick;
  } tmrbStrobe_t;
endpackage

// File: rtl/tmrb_ctrl.sv
module tmrb_ctrl
  import tmrb_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int TRIG_N = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWrEn,
  input  logic              enWrData,
  input  logic              extMode,
  input  logic [SEL_W-1:0]  trigSel,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [DIV_W-1:0]  divActive,
  input  logic              ovfEvt,
  output tmrbStrobe_t       strb
);
  logic             enReg;
  logic             enActive;
  logic             trigPrev;
  logic             trigSelected;
  logic             srcTick;
  logic             presHit;
  logic [DIV_W-1:0] presCnt;
  logic [TRIG_N-1:0] selHot;

  // one-hot decode of the selector; codes past TRIG_N-1 give no line
  for (genvar g = 0; g < TRIG_N; g++) begin : gSel
    assign selHot[g] = (trigSel == SEL_W'(g));
  end

  assign trigSelected = |(selHot & trigIn);
  assign srcTick      = extMode ? (trigSelected & ~trigPrev) : 1'b1;
  assign presHit      = (presCnt == divActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      enActive <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      if (enWrEn) enReg <= enWrData;
      enActive <= enReg;
      trigPrev <= trigSelected;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (!enActive || ovfEvt) begin
      presCnt <= '0;
    end else if (srcTick) begin
      presCnt <= presHit ? '0 : presCnt + 1'b1;
    end
  end

  always_comb begin
    strb.enActive = enActive;
    strb.cntTick  = enActive & srcTick & presHit;
  end

  // prescaler phase never runs past the divisor in use
  assert_pres_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= divActive);
  // an out-of-range select code produces no tick in external mode
  assert_no_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && (int'(trigSel) >= TRIG_N)) |-> !strb.cntTick);
  // enable written to 1 is seen by counting exactly one cycle later
  assert_en_delay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enWrEn && enWrData) |=> ##1 strb.enActive);
  // disabled timer keeps the prescaler phase at zero
  assert_pres_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enActive |=> (presCnt == '0));
endmodule

// File: rtl/tmrb_datapath.sv
module tmrb_datapath
  import tmrb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrbStrobe_t      strb,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             perWrEn,
  input  logic [CNT_W-1:0] perWrData,
  input  logic             perBufWrEn,
  input  logic             perBufWrData,
  input  logic             ovfEvtWrEn,
  input  logic             ovfEvtWrData,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic [DIV_W-1:0] divActive,
  output logic             ovfEvt
);
  logic [DIV_W-1:0] divPre;
  logic [CNT_W-1:0] perPre;
  logic [CNT_W-1:0] perShadow;
  logic             perBufEn;
  logic             ovfEvtEn;
  logic             wrap;

  assign wrap   = strb.cntTick && (count >= perShadow);
  assign ovfEvt = wrap && ovfEvtEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divPre   <= '0;
      perPre   <= '1;
      perBufEn <= 1'b0;
      ovfEvtEn <= 1'b1;
    end else begin
      if (divWrEn)    divPre   <= divWrData;
      if (perWrEn)    perPre   <= perWrData;
      if (perBufWrEn) perBufEn <= perBufWrData;
      if (ovfEvtWrEn) ovfEvtEn <= ovfEvtWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divActive <= '0;
      perShadow <= '1;
    end else begin
      if (ovfEvt) divActive <= divPre;
      if (perWrEn && !perBufEn) perShadow <= perWrData;
      else if (ovfEvt)          perShadow <= perPre;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.cntTick) begin
      count <= wrap ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ovfFlag <= 1'b0;
    else if (ovfEvt)  ovfFlag <= 1'b1;
    else if (flagClr) ovfFlag <= 1'b0;
  end

  // a step at or above the period returns the counter to zero
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntTick && count >= perShadow) |=> (count == '0));
  // divisor in use changes only on an overflow event
  assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ovfEvt |=> $stable(divActive));
  // the flag rises only after an enabled overflow event
  assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(ovfEvt));
  // flag stays set without a clear
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);
  // no count step means the counter holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntTick |=> $stable(count));
endmodule

// File: rtl/tmrb_top.sv
module tmrb_top
  import tmrb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int TRIG_N = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWrEn,
  input  logic              enWrData,
  input  logic              divWrEn,
  input  logic [DIV_W-1:0]  divWrData,
  input  logic              perWrEn,
  input  logic [CNT_W-1:0]  perWrData,
  input  logic              perBufWrEn,
  input  logic              perBufWrData,
  input  logic              ovfEvtWrEn,
  input  logic              ovfEvtWrData,
  input  logic              extMode,
  input  logic [SEL_W-1:0]  trigSel,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic              flagClr,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag
);
  tmrbStrobe_t      strb;
  logic [DIV_W-1:0] divActive;
  logic             ovfEvt;

  tmrb_ctrl #(.DIV_W(DIV_W), .TRIG_N(TRIG_N), .SEL_W(SEL_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enWrEn    (enWrEn),
    .enWrData  (enWrData),
    .extMode   (extMode),
    .trigSel   (trigSel),
    .trigIn    (trigIn),
    .divActive (divActive),
    .ovfEvt    (ovfEvt),
    .strb      (strb)
  );

  tmrb_datapath #(.CNT_W(CNT_W), .DIV_W(DIV_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .divWrEn      (divWrEn),
    .divWrData    (divWrData),
    .perWrEn      (perWrEn),
    .perWrData    (perWrData),
    .perBufWrEn   (perBufWrEn),
    .perBufWrData (perBufWrData),
    .ovfEvtWrEn   (ovfEvtWrEn),
    .ovfEvtWrData (ovfEvtWrData),
    .flagClr      (flagClr),
    .count        (count),
    .ovfFlag      (ovfFlag),
    .divActive    (divActive),
    .ovfEvt       (ovfEvt)
  );
endmodule

// File: tb/sim_tmrb_top.sv
module sim_tmrb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enWrEn = 0, enWrData = 0;
  logic        divWrEn = 0;
  logic [15:0] divWrData = '0;
  logic        perWrEn = 0;
  logic [15:0] perWrData = '0;
  logic        perBufWrEn = 0, perBufWrData = 0;
  logic        ovfEvtWrEn = 0, ovfEvtWrData = 0;
  logic        extMode = 0;
  logic [2:0]  trigSel = '0;
  logic [3:0]  trigIn = '0;
  logic        flagClr = 0;
  logic [15:0] count;
  logic        ovfFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] cnt;
    logic        flg;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  tmrb_top u0 (
    .clk(clk), .rstN(rstN),
    .enWrEn(enWrEn), .enWrData(enWrData),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .perWrEn(perWrEn), .perWrData(perWrData),
    .perBufWrEn(perBufWrEn), .perBufWrData(perBufWrData),
    .ovfEvtWrEn(ovfEvtWrEn), .ovfEvtWrData(ovfEvtWrData),
    .extMode(extMode), .trigSel(trigSel), .trigIn(trigIn),
    .flagClr(flagClr), .count(count), .ovfFlag(ovfFlag)
  );

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #4;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        testsRun++;
        if (count !== it.cnt || ovfFlag !== it.flg) begin
          testsFailed++;
          $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
                   it.tag, count, ovfFlag, it.cnt, it.flg);
        end
      end
    end
  end

  // driver: one clock edge, drop the pulse inputs, queue the expected state
  task automatic step(input int c, input bit f, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    enWrEn = 0; divWrEn = 0; perWrEn = 0; perBufWrEn = 0;
    ovfEvtWrEn = 0; flagClr = 0;
    it.cnt = 16'(c);
    it.flg = f;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      done = 1;
      testsFailed++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step(0, 0, "R10 reset state");

    // immediate period 4, overflow events on
    perWrEn = 1; perWrData = 16'd4;
    perBufWrEn = 1; perBufWrData = 0;
    ovfEvtWrEn = 1; ovfEvtWrData = 1;
    step(0, 0, "R10 disabled after reset");

    enWrEn = 1; enWrData = 1;
    step(0, 0, "R6 edge of enable write");
    step(0, 0, "R6 delayed enable");
    step(1, 0, "R6 first step");
    step(2, 0, "R1 count up");
    step(3, 0, "R1 count up");
    step(4, 0, "R4 immediate period reached");
    step(0, 1, "R1 wrap sets flag");

    flagClr = 1;
    step(1, 0, "R8 clear");
    step(2, 0, "R8 stays clear");
    step(3, 0, "R1");
    step(4, 0, "R1");
    flagClr = 1;
    step(0, 1, "R8 overflow wins over clear");

    // divisor 2 written mid-period: not used until the next event
    flagClr = 1; divWrEn = 1; divWrData = 16'd2;
    step(1, 0, "R3 old divisor kept");
    step(2, 0, "R3 old divisor kept");
    step(3, 0, "R3 old divisor kept");
    step(4, 0, "R3 old divisor kept");
    step(0, 1, "R3 event loads divisor");
    step(0, 1, "R2 divide by 3 hold");
    step(0, 1, "R2 divide by 3 hold");
    for (int v = 1; v <= 4; v++)
      for (int k = 0; k < 3; k++) step(v, 1, "R2 divide by 3");
    step(0, 1, "R2 wrap under prescaler");
    // write divisor 0 now; still divide by 3 until the next event
    flagClr = 1; divWrEn = 1; divWrData = 16'd0;
    step(0, 0, "R3 divisor pending");
    step(0, 0, "R3 divisor pending");
    for (int v = 1; v <= 4; v++)
      for (int k = 0; k < 3; k++) step(v, 0, "R3 divisor pending");
    step(0, 1, "R3 reload at event");
    step(1, 1, "R3 divisor 0 in use");
    step(2, 1, "R3 divisor 0 in use");

    // buffered period
    flagClr = 1; perBufWrEn = 1; perBufWrData = 1;
    step(3, 0, "R4 buffer bit set");
    perWrEn = 1; perWrData = 16'd2;
    step(4, 0, "R4 buffered period not yet active");
    step(0, 1, "R4 old period wrap");
    step(1, 1, "R4");
    step(2, 1, "R4 new period");
    step(0, 1, "R4 new period wrap");
    flagClr = 1;
    step(1, 0, "R8 clear");

    // overflow events off: wrap without reload or flag
    ovfEvtWrEn = 1; ovfEvtWrData = 0;
    perWrEn = 1; perWrData = 16'd3;
    divWrEn = 1; divWrData = 16'd1;
    step(2, 0, "R5");
    step(0, 0, "R5 wrap without flag");
    step(1, 0, "R5 divisor not reloaded");
    step(2, 0, "R5 period not reloaded");
    step(0, 0, "R5 wrap at old period");
    step(1, 0, "R5");

    // disable: one more step, then hold
    enWrEn = 1; enWrData = 0;
    step(2, 0, "R6 disable write edge");
    step(0, 0, "R6 last step after disable");
    step(0, 0, "R9 hold");
    step(0, 0, "R9 hold");
    ovfEvtWrEn = 1; ovfEvtWrData = 1;
    perBufWrEn = 1; perBufWrData = 0;
    step(0, 0, "R9 write while disabled");
    perWrEn = 1; perWrData = 16'd5;
    step(0, 0, "R9 period write while disabled");
    enWrEn = 1; enWrData = 1;
    step(0, 0, "R6");
    step(0, 0, "R6");
    for (int v = 1; v <= 5; v++) step(v, 0, "R9 new period counted");
    step(0, 1, "R9 wrap at period written while disabled");
    step(0, 1, "R2 divide by 2 hold");
    step(1, 1, "R2 divide by 2 step");

    // external trigger, divisor 1 in use
    extMode = 1; trigSel = 3'd1; flagClr = 1;
    step(1, 0, "R7 no trigger edge");
    trigIn = 4'b0001;
    step(1, 0, "R7 unselected line ignored");
    trigIn = 4'b0010;
    step(1, 0, "R7 first edge into prescaler");
    step(1, 0, "R7 level not counted");
    trigIn = 4'b0000;
    step(1, 0, "R7 falling edge");
    trigIn = 4'b0010;
    step(2, 0, "R7 second edge steps");
    trigIn = 4'b0000;
    step(2, 0, "R7");
    trigSel = 3'd4; trigIn = 4'b1111;
    step(2, 0, "R7 code 4 selects none");
    trigIn = 4'b0000;
    step(2, 0, "R7 code 4 selects none");
    trigIn = 4'b1111;
    step(2, 0, "R7 code 4 selects none");
    trigIn = 4'b0000;
    step(2, 0, "R7 code 4 selects none");

    @(posedge clk);
    #6;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule